// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits between the instruction fetch path and the execution core of a small stack processor. Each fetched 18-bit word packs up to three 5-bit opcodes. When memory signals that a word has arrived, the sequencer captures the word and issues its opcodes to the core one per clock cycle, starting with the most significant field. A one-hot slot register marks which field is being issued.

A word can end before all three fields are used. If an issued opcode transfers control or touches memory, the fields after it are dropped. A word also ends after its third field. When a word ends, the sequencer asks for the next word and holds that request until memory answers. While it waits, it issues nothing.

Top module: `slot_seq`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `fetch_req_o` is 1, `op_vld_o` is 0 and `op_o` is 0. A reset in the middle of a word drops that word.
- R2: Field positions are fixed. Slot 0 is `word_i[17:13]`, slot 1 is `word_i[12:8]` and slot 2 is `word_i[7:3]`. The fields are issued in that order, on consecutive cycles. The first field appears in the cycle after the edge at which ready was accepted.
- R3: Bits `word_i[2:0]` have no effect on any opcode that is issued.
- R4: An issued opcode whose most significant bit is 0 (values 0 to 15, which are transfers of control and memory accesses) is the last field issued from its word. The fields after it never appear.
- R5: A word always ends after slot 2. No more than three fields are issued for one accepted ready.
- R6: `rdy_i` is accepted only in a cycle where `fetch_req_o` is 1. While fields are being issued, `rdy_i` and `word_i` are ignored.
- R7: `fetch_req_o` rises in the cycle after the last field of a word. It falls in the cycle after ready is accepted. It is never high in the same cycle as `op_vld_o`.
- R8: While no ready arrives, the sequencer keeps waiting for any length of time. During that wait `op_vld_o` stays 0 and `fetch_req_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdy_i | input | 1 | Memory strobe: `word_i` holds a fetched word this cycle |
| word_i | input | 18 | Fetched word carrying the packed opcodes |
| op_o | output | 5 | Opcode being issued this cycle (registered) |
| op_vld_o | output | 1 | `op_o` holds a valid opcode this cycle |
| fetch_req_o | output | 1 | Sequencer is idle and asks for the next word |

## Verification
The bench builds the block with its default parameters: an 18-bit word, 5-bit opcodes and three slots. These values leave three spare low bits, so the bench can set those bits and show they have no effect. They also give every position where a word can end: after slot 0, after slot 1, or at the natural end after slot 2. The vector table mixes opcodes that end the word with opcodes that do not, in each slot. The directed tests cover ready pulses that arrive while a word is being issued, ready held high across back-to-back words, a long wait, and a reset in the middle of a word.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  // Lowest bit of field k inside the used (upper) part of the word.
  // Field 0 is the most significant one.
  function automatic int slot_lsb(input int used_w, input int op_w, input int k);
    return used_w - op_w * (k + 1);
  endfunction

endpackage

// File: rtl/slot_onehot_ring.sv
module slot_onehot_ring #(
  parameter int SLOTS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             clear,
  output logic [SLOTS-1:0] sel_d,
  output logic             last_q
);

  logic [SLOTS-1:0] sel_q;

  always_comb begin
    sel_d = sel_q;
    if (load)
      sel_d = {{(SLOTS-1){1'b0}}, 1'b1};
    else if (clear)
      sel_d = '0;
    else if (step)
      sel_d = sel_q << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end

  assign last_q = sel_q[SLOTS-1];

endmodule

// File: rtl/slot_field_pick.sv
module slot_field_pick #(
  parameter int USED_W = 15,
  parameter int OP_W   = 5,
  parameter int SLOTS  = 3
) (
  input  logic [USED_W-1:0] word,
  input  logic [SLOTS-1:0]  sel,
  output logic [OP_W-1:0]   op
);

  logic [OP_W-1:0] gated [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_field
    localparam int LSB = slot_seq_pkg::slot_lsb(USED_W, OP_W, k);
    assign gated[k] = word[LSB +: OP_W] & {OP_W{sel[k]}};
  end

  always_comb begin
    op = '0;
    for (int k = 0; k < SLOTS; k++)
      op = op | gated[k];
  end

endmodule

// File: rtl/slot_seq.sv
module slot_seq #(
  parameter int WORD_W = 18,
  parameter int OP_W   = 5,
  parameter int SLOTS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [OP_W-1:0]   op_o,
  output logic              op_vld_o,
  output logic              fetch_req_o
);

  localparam int USED_W = SLOTS * OP_W;
  localparam int SPARE_W = WORD_W - USED_W;

  logic [USED_W-1:0] word_q, word_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic              vld_q, req_q;
  logic [SLOTS-1:0]  sel_d;
  logic              last_q, load, ends, step;

  // Spare low bits carry no opcode.
  if (SPARE_W > 0) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^word_i[SPARE_W-1:0];
  end

  assign load   = req_q & rdy_i;
  // A word ends after its last slot or after a control/memory opcode (MSB clear).
  assign ends   = vld_q & (last_q | ~op_q[OP_W-1]);
  assign step   = vld_q & ~ends;
  assign word_d = load ? word_i[WORD_W-1 -: USED_W] : word_q;

  slot_onehot_ring #(.SLOTS(SLOTS)) ring_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .clear  (ends),
    .sel_d  (sel_d),
    .last_q (last_q)
  );

  slot_field_pick #(.USED_W(USED_W), .OP_W(OP_W), .SLOTS(SLOTS)) pick_i (
    .word (word_d),
    .sel  (sel_d),
    .op   (op_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      op_q   <= '0;
      vld_q  <= 1'b0;
      req_q  <= 1'b1;
    end else begin
      word_q <= word_d;
      op_q   <= op_d;
      vld_q  <= |sel_d;
      if (load)      req_q <= 1'b0;
      else if (ends) req_q <= 1'b1;
    end
  end

  assign op_o        = op_q;
  assign op_vld_o    = vld_q;
  assign fetch_req_o = req_q;

endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk #(
  parameter int OP_W  = 5,
  parameter int SLOTS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            rdy_i,
  input logic [OP_W-1:0] op_o,
  input logic            op_vld_o,
  input logic            fetch_req_o
);

  localparam int RUN_W = $clog2(SLOTS + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (op_vld_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (fetch_req_o && !op_vld_o));

  // R7
  req_vld_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req_o && op_vld_o));

  // R2
  accept_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && rdy_i) |=> (op_vld_o && !fetch_req_o));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_req_o && !rdy_i) |=> (fetch_req_o && !op_vld_o));

  // R4
  early_end_chk: assert property (@(posedge clk) disable iff (rst)
    (op_vld_o && !op_o[OP_W-1]) |=> (!op_vld_o && fetch_req_o));

  // R5
  slot_run_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_W'(SLOTS));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (op_vld_o && op_o[OP_W-1] && run_q < RUN_W'(SLOTS - 1)) |=> op_vld_o);

endmodule

bind slot_seq slot_seq_chk #(.OP_W(OP_W), .SLOTS(SLOTS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .rdy_i       (rdy_i),
  .op_o        (op_o),
  .op_vld_o    (op_vld_o),
  .fetch_req_o (fetch_req_o)
);

// File: tb/slot_seq_tb_top.sv
module slot_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdy_i = 1'b0;
  logic [17:0] word_i = '0;
  logic [4:0]  op_o;
  logic        op_vld_o, fetch_req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  slot_seq dut_i (
    .clk(clk), .rst(rst), .rdy_i(rdy_i), .word_i(word_i),
    .op_o(op_o), .op_vld_o(op_vld_o), .fetch_req_o(fetch_req_o)
  );

  localparam int NV = 8;
  localparam logic [17:0] VEC_W [NV] = '{
    {5'h1f, 5'h1e, 5'h1a, 3'd5},
    {5'h10, 5'h08, 5'h15, 3'd0},
    {5'h00, 5'h1f, 5'h1f, 3'd7},
    {5'h17, 5'h11, 5'h06, 3'd2},
    {5'h14, 5'h1b, 5'h0d, 3'd3},
    {5'h0f, 5'h1c, 5'h1d, 3'd1},
    {5'h18, 5'h03, 5'h19, 3'd6},
    {5'h1f, 5'h1e, 5'h1a, 3'd2}
  };
  localparam int VEC_N [NV] = '{3, 2, 1, 3, 3, 1, 2, 3};

  function automatic logic [4:0] exp_op(input logic [17:0] w, input int k);
    case (k)
      0:       return w[17:13];
      1:       return w[12:8];
      default: return w[7:3];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Offers word w, then collects issued opcodes. Optionally drives a
  // conflicting ready/word while the slots are being issued.
  task automatic run_word(input logic [17:0] w, input int n_exp,
                          input bit noisy, input bit keep_rdy);
    int cnt = 0;
    int guard = 0;
    while (!fetch_req_o && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    rdy_i  = 1'b1;
    word_i = w;
    @(negedge clk);
    rdy_i = keep_rdy;
    if (noisy) begin
      rdy_i  = 1'b1;
      word_i = ~w;
    end
    while (op_vld_o && cnt < 5) begin
      check(op_o == exp_op(w, cnt), "R2 slot order", op_o, exp_op(w, cnt));
      check(!fetch_req_o, "R7 req low while issuing", fetch_req_o, 0);
      cnt++;
      @(negedge clk);
    end
    if (!keep_rdy) rdy_i = 1'b0;
    check(cnt == n_exp, "R4/R5 slot count", cnt, n_exp);
    check(fetch_req_o, "R7 req after word end", fetch_req_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fetch_req_o && !op_vld_o && op_o == 0, "R1 reset state",
          {fetch_req_o, op_vld_o}, 2);
    rst = 1'b0;
    @(negedge clk);
    check(fetch_req_o && !op_vld_o && op_o == 0, "R1 after release",
          {fetch_req_o, op_vld_o}, 2);

    // Table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) run_word(VEC_W[i], VEC_N[i], 1'b0, 1'b0);

    // R3: same fields, different spare bits -> same opcodes
    run_word({5'h1d, 5'h1c, 5'h1b, 3'd0}, 3, 1'b0, 1'b0);
    run_word({5'h1d, 5'h1c, 5'h1b, 3'd7}, 3, 1'b0, 1'b0);

    // R6: ready and a different word while busy are ignored
    run_word({5'h11, 5'h12, 5'h13, 3'd0}, 3, 1'b1, 1'b0);
    run_word({5'h1e, 5'h09, 5'h13, 3'd0}, 2, 1'b1, 1'b0);

    // R8: long wait with no ready
    begin
      bit held = 1'b1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (op_vld_o || !fetch_req_o) held = 1'b0;
      end
      check(held, "R8 idle hold", {fetch_req_o, op_vld_o}, 2);
    end

    // R7: ready held high across back-to-back words
    run_word({5'h1a, 5'h1b, 5'h1c, 3'd0}, 3, 1'b0, 1'b1);
    run_word({5'h05, 5'h1b, 5'h1c, 3'd0}, 1, 1'b0, 1'b0);

    // R1: reset in the middle of a word
    rdy_i  = 1'b1;
    word_i = {5'h1f, 5'h1f, 5'h1f, 3'd0};
    @(negedge clk);
    rdy_i = 1'b0;
    check(op_vld_o, "R1 word started", op_vld_o, 1);
    rst = 1'b1;
    @(negedge clk);
    check(fetch_req_o && !op_vld_o && op_o == 0, "R1 mid-word reset",
          {fetch_req_o, op_vld_o}, 2);
    rst = 1'b0;
    @(negedge clk);
    check(fetch_req_o && !op_vld_o, "R1 dropped word", {fetch_req_o, op_vld_o}, 2);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule